// File: doc/BRIEF.md
# Two-Wire Bus Target with Clock-Hold Handshake

This block is the target side of an I2C-style two-wire bus. A local host configures and services it through a small register port. The block samples the bus lines SCL and SDA on the system clock. It finds START and STOP conditions, shifts in the 7-bit address and the direction bit, and decides whether to answer. Each event the host has to handle raises a flag. The block then holds SCL low until the host reacts.

There are two flags. The first is shared by address matches and STOP conditions; a kind bit in the status register says which of the two set it. The second covers data bytes. Each flag drives an interrupt output, and that output is also gated by a global interrupt-enable input. The host can release a held bus in two ways. One is an explicit command. The other, available only in smart mode, is any read or write of the data register. The ACK or NACK that the block drives comes from a stored ack-action bit. The pads are open-drain: the two `Oe` outputs pull a line low when they are 1.

Register map (3-bit `regAddr`):
- 0 control: bit 7 data interrupt enable, bit 6 address/stop interrupt enable, bit 5 stop reporting enable, bit 2 accept-any-address, bit 1 smart mode, bit 0 enable.
- 1 command: bits 1:0 code (0 none, 2 finish, 3 respond), bit 2 ack action (0 ACK, 1 NACK).
- 2 status: bit 0 data flag, bit 1 address/stop flag, bit 2 kind (1 address, 0 STOP), bit 3 direction (1 = bus controller reads), bit 4 clock held.
- 3 own address: bits 6:0.
- 4 data.

Top module: `i2c_target`

## Requirements
- R1: After reset, every register reads 0. Both pad enables are 0 and both interrupts are low.
- R2: The control register stores bits 7, 6, 5, 2, 1 and 0. Bits 4:3 always read back 0. The command register reads back the ack-action bit in bit 2 and 0 elsewhere.
- R3: While the enable bit is 0, the block drives neither line and sets no flag, whatever happens on the bus.
- R4: The address byte arrives MSB first and ends with the direction bit. If its upper 7 bits equal the own-address register, the block flags it. If they differ and accept-any-address is 0, the block does not ACK, does not hold SCL and sets no flag.
- R5: With accept-any-address set, every address is flagged and can be acknowledged. The data register then holds the received address byte.
- R6: A flagged address sets the address/stop flag with kind 1 and records the direction bit. SCL stays low until the host acts.
- R7: A STOP after the block was addressed sets the address/stop flag with kind 0. It does so only when stop reporting is enabled.
- R8: The data interrupt is high exactly when the data interrupt enable, the data flag and the global enable input are all 1.
- R9: The address/stop interrupt is high only when its enable, its flag, stop reporting and the global enable input are all 1.
- R10: With smart mode off, a data register access neither releases SCL nor clears a flag. Command code 3 releases the bus and drives the ack-action bit as the answer. A received byte can be read from the data register.
- R11: With smart mode on, a read or write of the data register clears the flags and releases the bus. In a read transfer, the byte written to the data register is shifted out MSB first.
- R12: Command code 2 clears both flags and releases SCL without driving an ACK. Further bytes are then ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects in smart mode) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| gie | input | 1 | Global interrupt enable |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low (clock hold) |
| sdaOe | output | 1 | Pull SDA low |
| dataIrq | output | 1 | Data event interrupt |
| apIrq | output | 1 | Address/STOP event interrupt |

## Verification
A wrong internal bit count or phase shows up on the bus within one byte. The ACK arrives a bit early or late, or SCL is held at the wrong place, and the bus controller reads the wrong ACK level or never gets its clock back. A wrong flag state shows at the interrupt pins in the cycle after the event. The scoreboard compares the order of interrupt events against the order each scenario predicts, so a missing, extra or swapped address, data or STOP event fails at once. Bytes moved in either direction are compared at the bus side and at the register side of the same transfer.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_SMART  = 1;
  localparam int CB_ANY    = 2;
  localparam int CB_STOPEN = 5;
  localparam int CB_APIE   = 6;
  localparam int CB_DIE    = 7;
  localparam logic [7:0] CTRL_MASK = 8'hE7;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_RSV  = 2'd1,
    CMD_DONE = 2'd2,
    CMD_RESP = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WR   = 2'd2,
    PH_RD   = 2'd3
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic             relBus;    // host let the held bus go
    logic             complete;  // finish, wait for START
    logic             nack;      // answer to drive on the ack slot
    logic [BYTE_W-1:0] loadVal;  // byte to shift out in a read
  } hostStrb_t;

  // datapath -> control
  typedef struct packed {
    logic             addrEvt;
    logic             dataEvt;
    logic             stopEvt;
    logic             rw;
    logic             held;
    logic [BYTE_W-1:0] rxByte;
  } busEvt_t;
endpackage

// File: rtl/i2ct_dp.sv
module i2ct_dp
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic            enable,
  input  logic            anyAddr,
  input  logic [6:0]      ownAddr,
  input  hostStrb_t       strb,
  output busEvt_t         evt,
  output logic            sclOe,
  output logic            sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSy, sdaSy;
  logic sclS, sdaS, sclP, sdaP;
  logic startDet, stopDet, sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shReg;
  phase_e phase;
  logic hold, relPend, nackSent, addressed, rwReg;
  logic addrEvt, dataEvt, stopEvt;
  logic addrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSy <= '1;
      sdaSy <= '1;
    end else begin
      sclSy <= {sclSy[SYNC_STAGES-2:0], sclIn};
      sdaSy <= {sdaSy[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS     = sclSy[SYNC_STAGES-1];
  assign sdaS     = sdaSy[SYNC_STAGES-1];
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet  = sclS && sclP && !sdaP && sdaS;
  assign sclRise  = sclS && !sclP;
  assign sclFall  = !sclS && sclP;
  assign addrHit  = anyAddr || (shReg[7:1] == ownAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclP <= 1'b1; sdaP <= 1'b1;
      bitCnt <= '0; shReg <= '0; phase <= PH_IDLE;
      hold <= 1'b0; relPend <= 1'b0; nackSent <= 1'b0;
      addressed <= 1'b0; rwReg <= 1'b0; sdaOe <= 1'b0;
      addrEvt <= 1'b0; dataEvt <= 1'b0; stopEvt <= 1'b0;
    end else begin
      sclP <= sclS; sdaP <= sdaS;
      addrEvt <= 1'b0; dataEvt <= 1'b0; stopEvt <= 1'b0;
      if (!enable) begin
        phase <= PH_IDLE; hold <= 1'b0; relPend <= 1'b0;
        sdaOe <= 1'b0; bitCnt <= '0; addressed <= 1'b0;
      end else if (startDet) begin
        phase <= PH_ADDR; bitCnt <= '0; hold <= 1'b0;
        relPend <= 1'b0; sdaOe <= 1'b0;
      end else if (stopDet) begin
        stopEvt <= addressed; addressed <= 1'b0;
        phase <= PH_IDLE; hold <= 1'b0; relPend <= 1'b0;
        sdaOe <= 1'b0; bitCnt <= '0;
      end else if (strb.complete) begin
        phase <= PH_IDLE; hold <= 1'b0; relPend <= 1'b0;
        sdaOe <= 1'b0; bitCnt <= '0;
      end else if (hold) begin
        // SDA is set first, SCL follows one cycle later
        if (relPend) begin
          hold <= 1'b0; relPend <= 1'b0;
        end else if (strb.relBus) begin
          relPend <= 1'b1;
          if (bitCnt == LAST_BIT) begin
            sdaOe <= !strb.nack; nackSent <= strb.nack;
          end else begin
            shReg <= strb.loadVal; sdaOe <= !strb.loadVal[BYTE_W-1];
          end
        end
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (phase != PH_RD && bitCnt < LAST_BIT) shReg <= {shReg[BYTE_W-2:0], sdaS};
          if (phase == PH_RD && bitCnt == LAST_BIT) nackSent <= sdaS;
        end else if (sclFall) begin
          if (phase == PH_RD && bitCnt < LAST_BIT) begin
            shReg <= {shReg[BYTE_W-2:0], 1'b0};
            sdaOe <= !shReg[BYTE_W-2];
          end else if (phase == PH_RD && bitCnt == LAST_BIT) begin
            sdaOe <= 1'b0;
          end else if (bitCnt == LAST_BIT) begin
            if (phase == PH_ADDR && !addrHit) begin
              phase <= PH_IDLE;
            end else if (phase == PH_ADDR) begin
              hold <= 1'b1; addrEvt <= 1'b1; addressed <= 1'b1; rwReg <= shReg[0];
            end else begin
              hold <= 1'b1; dataEvt <= 1'b1;
            end
          end else if (bitCnt == ACK_BIT) begin
            bitCnt <= '0; sdaOe <= 1'b0;
            if (nackSent) phase <= PH_IDLE;
            else if (phase == PH_ADDR) begin
              if (rwReg) begin
                phase <= PH_RD; hold <= 1'b1; dataEvt <= 1'b1;
              end else phase <= PH_WR;
            end else if (phase == PH_RD) begin
              hold <= 1'b1; dataEvt <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sclOe = hold;
  always_comb begin
    evt.addrEvt = addrEvt;
    evt.dataEvt = dataEvt;
    evt.stopEvt = stopEvt;
    evt.rw      = rwReg;
    evt.held    = hold;
    evt.rxByte  = shReg;
  end

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclOe && !sdaOe));

  assert_hold_until_host_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hold && enable && !relPend && !strb.relBus && !strb.complete && !startDet && !stopDet)
      |=> hold);

  assert_miss_no_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !hold && !startDet && !stopDet && !strb.complete && sclFall &&
     phase == PH_ADDR && bitCnt == LAST_BIT && !anyAddr && shReg[7:1] != ownAddr)
      |=> (!sclOe && !addrEvt));
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              gie,
  input  busEvt_t           evt,
  output hostStrb_t         strb,
  output logic              enable,
  output logic              anyAddr,
  output logic [6:0]        ownAddr,
  output logic              dataIrq,
  output logic              apIrq
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_OWN  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(4);

  logic [BYTE_W-1:0] ctrlReg, dataReg;
  logic [6:0] ownReg;
  logic ackAct, difFlag, apFlag, apKind, dirBit;
  logic cmdWr, dataWr, dataRd;
  cmd_e cmdCode;

  assign cmdWr   = regWr && regAddr == A_CMD;
  assign dataWr  = regWr && regAddr == A_DATA;
  assign dataRd  = regRd && regAddr == A_DATA;
  assign cmdCode = cmd_e'(regWdata[1:0]);

  always_comb begin
    strb.relBus   = (cmdWr && cmdCode == CMD_RESP) ||
                    (ctrlReg[CB_SMART] && (dataWr || dataRd));
    strb.complete = cmdWr && cmdCode == CMD_DONE;
    strb.nack     = cmdWr ? regWdata[2] : ackAct;
    strb.loadVal  = dataWr ? regWdata : dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0; dataReg <= '0; ownReg <= '0; ackAct <= 1'b0;
      difFlag <= 1'b0; apFlag <= 1'b0; apKind <= 1'b0; dirBit <= 1'b0;
    end else begin
      if (regWr && regAddr == A_CTRL) ctrlReg <= regWdata & CTRL_MASK;
      if (regWr && regAddr == A_OWN)  ownReg  <= regWdata[6:0];
      if (cmdWr) ackAct <= regWdata[2];
      if (dataWr) dataReg <= regWdata;
      if (strb.relBus || strb.complete) begin
        difFlag <= 1'b0; apFlag <= 1'b0;
      end
      if (evt.addrEvt) begin
        apFlag <= 1'b1; apKind <= 1'b1; dirBit <= evt.rw; dataReg <= evt.rxByte;
      end
      if (evt.dataEvt) begin
        difFlag <= 1'b1;
        if (!dirBit) dataReg <= evt.rxByte;
      end
      if (evt.stopEvt && ctrlReg[CB_STOPEN]) begin
        apFlag <= 1'b1; apKind <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdata = ctrlReg;
      A_CMD:   regRdata = {5'd0, ackAct, 2'd0};
      A_STAT:  regRdata = {3'd0, evt.held, dirBit, apKind, apFlag, difFlag};
      A_OWN:   regRdata = {1'b0, ownReg};
      A_DATA:  regRdata = dataReg;
      default: regRdata = '0;
    endcase
  end

  assign enable  = ctrlReg[CB_EN];
  assign anyAddr = ctrlReg[CB_ANY];
  assign ownAddr = ownReg;
  assign dataIrq = ctrlReg[CB_DIE] & difFlag & gie;
  assign apIrq   = ctrlReg[CB_APIE] & apFlag & ctrlReg[CB_STOPEN] & gie;

  assert_addr_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    evt.addrEvt |=> (apFlag && apKind));

  assert_stop_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stopEvt && !ctrlReg[CB_STOPEN] && !apFlag && !(regWr && regAddr == A_CTRL))
      |=> !apFlag);

  assert_data_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evt.dataEvt && ctrlReg[CB_DIE] && gie && !(regWr && regAddr == A_CTRL)) |=> difFlag);
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       gie,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       dataIrq,
  output logic       apIrq
);
  hostStrb_t strb;
  busEvt_t evt;
  logic enable, anyAddr;
  logic [6:0] ownAddr;

  i2ct_ctrl #(.REG_AW(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .gie(gie), .evt(evt), .strb(strb),
    .enable(enable), .anyAddr(anyAddr), .ownAddr(ownAddr),
    .dataIrq(dataIrq), .apIrq(apIrq)
  );

  i2ct_dp #(.SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .enable(enable),
    .anyAddr(anyAddr), .ownAddr(ownAddr), .strb(strb), .evt(evt),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );
endmodule

// File: tb/i2c_target_tb_top.sv
`timescale 1ns/1ps
module i2c_target_tb_top;
  localparam int H = 10;
  localparam int K_AP = 1;
  localparam int K_DAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic gie = 1'b1;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclOe, sdaOe, dataIrq, apIrq;
  wire sclLine = sclM & ~sclOe;
  wire sdaLine = sdaM & ~sdaOe;

  int total = 0, fails = 0;
  int expQ[$];
  logic sawDrive = 1'b0;
  logic apPrev = 1'b0, datPrev = 1'b0;

  always #10 clk = ~clk;

  i2c_target dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .gie(gie), .sclIn(sclLine),
    .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .dataIrq(dataIrq), .apIrq(apIrq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int k);
    expQ.push_back(k);
  endtask

  task automatic popCmp(string req, int k);
    if (expQ.size() == 0) chk({req, " unexpected event"}, k, 0);
    else chk({req, " event order"}, k, expQ.pop_front());
  endtask

  // monitor: interrupt rising edges in the order the design produces them
  always @(negedge clk) begin
    if (rstN) begin
      if (apIrq && !apPrev) popCmp("R9", K_AP);
      if (dataIrq && !datPrev) popCmp("R8", K_DAT);
    end
    apPrev = apIrq;
    datPrev = dataIrq;
    if (sclOe || sdaOe) sawDrive = 1'b1;
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 v = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic sclHigh();
    sclM = 1'b1; waitCyc(1);
    while (!sclLine) waitCyc(1);
  endtask

  task automatic mStart();
    sdaM = 1'b1; sclM = 1'b1; waitCyc(H);
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b0;
  endtask

  task automatic mStop();
    sdaM = 1'b0; waitCyc(H);
    sclHigh(); waitCyc(H);
    sdaM = 1'b1; waitCyc(H);
  endtask

  task automatic mWriteBit(logic b);
    sdaM = b; waitCyc(H);
    sclHigh(); waitCyc(H);
    sclM = 1'b0;
  endtask

  task automatic mReadBit(output logic b);
    sdaM = 1'b1; waitCyc(H);
    sclHigh(); waitCyc(H / 2);
    b = sdaLine; waitCyc(H - H / 2);
    sclM = 1'b0;
  endtask

  task automatic mSendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) mWriteBit(v[i]);
    mReadBit(ack);
  endtask

  task automatic mRecvByte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) mReadBit(v[i]);
    mWriteBit(nack);
  endtask

  task automatic waitAp();
    while (!apIrq) waitCyc(1);
  endtask

  task automatic waitDat();
    while (!dataIrq) waitCyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    logic a1, a2, a3;
    waitCyc(5); rstN = 1'b1; waitCyc(2);

    // R1 reset state
    rdReg(0, s); chk("R1 ctrl reset", s, 0);
    rdReg(2, s); chk("R1 status reset", s, 0);
    rdReg(4, s); chk("R1 data reset", s, 0);
    rdReg(3, s); chk("R1 own addr reset", s, 0);
    chk("R1 pads released", {sclOe, sdaOe}, 0);
    chk("R1 irqs low", {apIrq, dataIrq}, 0);

    // R2 register field layout
    wrReg(0, 8'hFF); rdReg(0, s); chk("R2 ctrl unused bits", s, 8'hE7);
    wrReg(1, 8'h04); rdReg(1, s); chk("R2 ack action readback", s, 8'h04);
    wrReg(1, 8'h00); wrReg(0, 8'h00);
    wrReg(3, 8'h2A); rdReg(3, s); chk("R2 own addr", s, 8'h2A);

    // R3 disabled block ignores a matching address
    sawDrive = 1'b0;
    mStart(); mSendByte(8'h54, a1); mStop();
    chk("R3 no ack while disabled", a1, 1);
    chk("R3 no drive while disabled", sawDrive, 0);
    rdReg(2, s); chk("R3 no flags while disabled", s, 0);

    // R4 address mismatch
    wrReg(0, 8'hE1);
    sawDrive = 1'b0;
    mStart(); mSendByte(8'h22, a1); mStop();
    chk("R4 mismatch not acked", a1, 1);
    chk("R4 mismatch no hold", sawDrive, 0);

    // R6 R7 R10 write transfer, smart mode off
    expect_ev(K_AP); expect_ev(K_DAT); expect_ev(K_AP);
    fork
      begin
        mStart(); mSendByte(8'h54, a1); mSendByte(8'h5A, a2); mStop();
      end
      begin
        waitAp(); rdReg(2, s); chk("R6 status after address", s[4:0], 5'b10110);
        waitCyc(40); chk("R6 clock held", sclOe, 1);
        rdReg(4, s); chk("R10 data holds address byte", s, 8'h54);
        waitCyc(3); chk("R10 data read keeps hold", sclOe, 1);
        rdReg(2, s); chk("R10 data read keeps flag", s[1], 1);
        wrReg(1, 8'h03);
        waitDat(); rdReg(4, s); chk("R10 received byte", s, 8'h5A);
        wrReg(1, 8'h07);
        waitAp(); rdReg(2, s); chk("R7 stop kind", s[2:1], 2'b01);
        wrReg(1, 8'h02);
      end
    join
    chk("R4 match acked", a1, 0);
    chk("R10 nack from ack action", a2, 1);

    // R5 accept any address
    wrReg(0, 8'hE5);
    expect_ev(K_AP); expect_ev(K_AP);
    fork
      begin mStart(); mSendByte(8'h22, a1); mStop(); end
      begin
        waitAp(); rdReg(4, s); chk("R5 address byte in data", s, 8'h22);
        wrReg(1, 8'h03);
        waitAp(); wrReg(1, 8'h02);
      end
    join
    chk("R5 any address acked", a1, 0);

    // R11 smart mode write
    wrReg(0, 8'hE3);
    expect_ev(K_AP); expect_ev(K_DAT); expect_ev(K_AP);
    fork
      begin mStart(); mSendByte(8'h54, a1); mSendByte(8'hC3, a2); mStop(); end
      begin
        waitAp(); rdReg(4, s);
        waitDat(); rdReg(4, s); chk("R11 smart received byte", s, 8'hC3);
        waitAp(); wrReg(1, 8'h02);
      end
    join
    chk("R11 smart address ack", a1, 0);
    chk("R11 smart data ack", a2, 0);

    // R11 R6 smart mode read
    expect_ev(K_AP); expect_ev(K_DAT); expect_ev(K_AP);
    fork
      begin mStart(); mSendByte(8'h55, a1); mRecvByte(v, 1'b1); mStop(); end
      begin
        waitAp(); rdReg(2, s); chk("R6 read direction bit", s[3], 1);
        rdReg(4, s);
        waitDat(); wrReg(4, 8'h96);
        waitAp(); wrReg(1, 8'h02);
      end
    join
    chk("R11 read address ack", a1, 0);
    chk("R11 byte shifted out", v, 8'h96);

    // R7 R8 R9 stop reporting off, global enable gating
    wrReg(0, 8'hC1);
    gie = 1'b0;
    expect_ev(K_DAT);
    fork
      begin mStart(); mSendByte(8'h54, a1); mSendByte(8'h12, a2); mStop(); end
      begin
        s = 8'h00;
        while (!s[1]) rdReg(2, s);
        gie = 1'b1; waitCyc(1);
        chk("R9 no ap irq without stop enable", apIrq, 0);
        gie = 1'b0;
        wrReg(1, 8'h03);
        s = 8'h00;
        while (!s[0]) rdReg(2, s);
        chk("R8 data irq masked by gie", dataIrq, 0);
        gie = 1'b1; waitCyc(1);
        chk("R8 data irq with gie", dataIrq, 1);
        wrReg(1, 8'h03);
      end
    join
    waitCyc(5);
    rdReg(2, s); chk("R7 stop not reported when disabled", s[1], 0);
    chk("R8 data byte acked", a2, 0);

    // R12 finish command
    wrReg(0, 8'hE1);
    expect_ev(K_AP); expect_ev(K_DAT); expect_ev(K_AP);
    fork
      begin
        mStart(); mSendByte(8'h54, a1); mSendByte(8'h33, a2);
        sawDrive = 1'b0;
        mSendByte(8'h44, a3);
        chk("R12 bytes ignored after finish", sawDrive, 0);
        chk("R12 later byte not acked", a3, 1);
        mStop();
      end
      begin
        waitAp(); wrReg(1, 8'h03);
        waitDat(); wrReg(1, 8'h02);
        rdReg(2, s); chk("R12 flags and hold cleared", {s[4], s[1:0]}, 0);
        waitAp(); wrReg(1, 8'h02);
      end
    join
    chk("R12 finished byte not acked", a2, 1);

    waitCyc(10);
    chk("R9 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule